// File: doc/BRIEF.md
# Interrupt-capable GPIO bank controller

This block manages a bank of 32 general-purpose pins behind a simple register port. Software sets the value each pin drives and whether it drives at all. It reads back the pad levels after they pass through a two-flop synchronizer. It can also ask any pin to raise an interrupt when it sees a level or an edge. Pull-resistor settings are held in two plain registers and sent straight to the pad cells.

Each pin's trigger is chosen by three configuration bits. A type bit selects level or edge detection. A both-edges bit overrides the polarity bit in edge mode. The polarity bit selects high/rising or low/falling. Detected events are latched into a raw status register. A separate mask gives the masked status, and the OR of the masked status drives a single interrupt line. Software acknowledges events by writing ones to a clear register.

The register port works in one cycle. The read data is a combinational function of the address. A write takes effect at the next rising clock edge.

Top module: `gpio_irq_bank`

## Requirements
- R1: Asynchronous active-low reset clears every register to zero. After reset all pins are inputs (padOe zero), the interrupt is masked and irqOut is low.
- R2: The output data register (offset 0x04) and the output-enable register (offset 0x08) can be read and written, and they drive padOut and padOe bit for bit.
- R3: Offset 0x00 returns padIn after a two-flop synchronizer. A pad change sampled at rising edge k becomes readable after edge k+1.
- R4: When a pin's type bit (offset 0x0c) is 1, its raw status bit (offset 0x1c) sets on every cycle that the synchronized pad equals its polarity bit (offset 0x14). It therefore sets again on the cycle after a clear if the level is still active.
- R5: When the type bit is 0 and the both-edges bit (offset 0x10) is 0, raw status sets on a rising edge if polarity is 1 and on a falling edge if polarity is 0. An edge is a change between the synchronized value and its value one cycle earlier.
- R6: When the type bit is 0 and the both-edges bit is 1, raw status sets on either edge whatever the polarity bit holds.
- R7: Masked status (offset 0x20) equals raw status AND the mask (offset 0x18, 1 = enabled). irqOut is high exactly when any masked-status bit is 1.
- R8: Writing a 1 to a bit of the clear register (offset 0x24) clears that raw status bit. A 0 bit has no effect, and the register reads as zero. An event detected on the same cycle as a clear for that pin leaves the bit set.
- R9: Offset 0x34 (pull direction, 1 = up) and offset 0x38 (pull enable, 0 = off) can be read and written, and they drive pullUp and pullEn.
- R10: Unmapped offsets read as zero and ignore writes. Writes to the input, raw-status and masked-status offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regAddr | input | 8 | Byte offset of the register accessed |
| regWrEn | input | 1 | Write strobe, applied at the next rising edge |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr, same cycle |
| padIn | input | 32 | Pad input levels (asynchronous) |
| padOut | output | 32 | Output data to the pads |
| padOe | output | 32 | Per-pin output enable |
| pullUp | output | 32 | Pull direction, 1 = up |
| pullEn | output | 32 | Pull resistor enable |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is an edge event and a clear for the same pin landing on the same clock. The event surfaces two synchronizer stages after the pad moves, so its cycle cannot be chosen directly. The stimulus toggles the pad and then issues the clear after a delay that is swept from zero to three cycles, which places one clear on the detection cycle. The level-mode case, where the bit sets again right after a clear, is reached by clearing while the pad is held active.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_IN    = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_OUT   = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_OE    = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_TYPE  = 8'h0c;
  localparam logic [ADDR_W-1:0] OFS_DUAL  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_POL   = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_RAW   = 8'h1c;
  localparam logic [ADDR_W-1:0] OFS_MSTAT = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_PSEL  = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_PEN   = 8'h38;

  typedef enum logic [3:0] {
    RD_NONE, RD_IN, RD_OUT, RD_OE, RD_TYPE, RD_DUAL, RD_POL,
    RD_MASK, RD_RAW, RD_MSTAT, RD_PSEL, RD_PEN
  } rdSel_e;

  typedef struct packed {
    logic   wrOut;
    logic   wrOe;
    logic   wrType;
    logic   wrDual;
    logic   wrPol;
    logic   wrMask;
    logic   wrClr;
    logic   wrPsel;
    logic   wrPen;
    rdSel_e rdSel;
  } regStrobe_t;

endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
(
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output regStrobe_t        stb
);

  always_comb begin
    stb       = '0;
    stb.rdSel = RD_NONE;
    unique case (regAddr)
      OFS_IN:    stb.rdSel = RD_IN;
      OFS_OUT:   begin stb.rdSel = RD_OUT;   stb.wrOut  = regWrEn; end
      OFS_OE:    begin stb.rdSel = RD_OE;    stb.wrOe   = regWrEn; end
      OFS_TYPE:  begin stb.rdSel = RD_TYPE;  stb.wrType = regWrEn; end
      OFS_DUAL:  begin stb.rdSel = RD_DUAL;  stb.wrDual = regWrEn; end
      OFS_POL:   begin stb.rdSel = RD_POL;   stb.wrPol  = regWrEn; end
      OFS_MASK:  begin stb.rdSel = RD_MASK;  stb.wrMask = regWrEn; end
      OFS_RAW:   stb.rdSel = RD_RAW;
      OFS_MSTAT: stb.rdSel = RD_MSTAT;
      OFS_CLR:   stb.wrClr = regWrEn;
      OFS_PSEL:  begin stb.rdSel = RD_PSEL;  stb.wrPsel = regWrEn; end
      OFS_PEN:   begin stb.rdSel = RD_PEN;   stb.wrPen  = regWrEn; end
      default:   stb.rdSel = RD_NONE;
    endcase
  end

endmodule

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect (
  input  logic levelMode,
  input  logic bothEdges,
  input  logic activeHigh,
  input  logic cur,
  input  logic prev,
  output logic hit
);

  logic rise;
  logic fall;

  assign rise = cur & ~prev;
  assign fall = ~cur & prev;

  always_comb begin
    if (levelMode)
      hit = activeHigh ? cur : ~cur;
    else if (bothEdges)
      hit = rise | fall;
    else
      hit = activeHigh ? rise : fall;
  end

endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int PINS = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  regStrobe_t      stb,
  input  logic [PINS-1:0] wdata,
  input  logic [PINS-1:0] padIn,
  output logic [PINS-1:0] rdata,
  output logic [PINS-1:0] padOut,
  output logic [PINS-1:0] padOe,
  output logic [PINS-1:0] pullUp,
  output logic [PINS-1:0] pullEn,
  output logic [PINS-1:0] rawStat,
  output logic [PINS-1:0] maskReg,
  output logic            irqOut
);

  logic [PINS-1:0] outReg, oeReg, typeReg, dualReg, polReg, pselReg, penReg;
  logic [PINS-1:0] padMeta, padSync, padPrev;
  logic [PINS-1:0] evt;
  logic [PINS-1:0] clrBits;
  logic [PINS-1:0] mStat;

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outReg  <= '0;
      oeReg   <= '0;
      typeReg <= '0;
      dualReg <= '0;
      polReg  <= '0;
      maskReg <= '0;
      pselReg <= '0;
      penReg  <= '0;
    end else begin
      if (stb.wrOut)  outReg  <= wdata;
      if (stb.wrOe)   oeReg   <= wdata;
      if (stb.wrType) typeReg <= wdata;
      if (stb.wrDual) dualReg <= wdata;
      if (stb.wrPol)  polReg  <= wdata;
      if (stb.wrMask) maskReg <= wdata;
      if (stb.wrPsel) pselReg <= wdata;
      if (stb.wrPen)  penReg  <= wdata;
    end
  end

  // two-flop synchronizer plus one history stage for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      padMeta <= '0;
      padSync <= '0;
      padPrev <= '0;
    end else begin
      padMeta <= padIn;
      padSync <= padMeta;
      padPrev <= padSync;
    end
  end

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    gpio_pin_detect u_det (
      .levelMode (typeReg[i]),
      .bothEdges (dualReg[i]),
      .activeHigh(polReg[i]),
      .cur       (padSync[i]),
      .prev      (padPrev[i]),
      .hit       (evt[i])
    );
  end

  assign clrBits = stb.wrClr ? wdata : '0;

  // new events win over a clear on the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rawStat <= '0;
    else        rawStat <= (rawStat & ~clrBits) | evt;
  end

  assign mStat  = rawStat & maskReg;
  assign irqOut = |mStat;

  assign padOut = outReg;
  assign padOe  = oeReg;
  assign pullUp = pselReg;
  assign pullEn = penReg;

  always_comb begin
    unique case (stb.rdSel)
      RD_IN:    rdata = padSync;
      RD_OUT:   rdata = outReg;
      RD_OE:    rdata = oeReg;
      RD_TYPE:  rdata = typeReg;
      RD_DUAL:  rdata = dualReg;
      RD_POL:   rdata = polReg;
      RD_MASK:  rdata = maskReg;
      RD_RAW:   rdata = rawStat;
      RD_MSTAT: rdata = mStat;
      RD_PSEL:  rdata = pselReg;
      RD_PEN:   rdata = penReg;
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int PINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [PINS-1:0]   regWdata,
  output logic [PINS-1:0]   regRdata,
  input  logic [PINS-1:0]   padIn,
  output logic [PINS-1:0]   padOut,
  output logic [PINS-1:0]   padOe,
  output logic [PINS-1:0]   pullUp,
  output logic [PINS-1:0]   pullEn,
  output logic              irqOut
);

  regStrobe_t      stb;
  logic [PINS-1:0] rawStat;
  logic [PINS-1:0] maskReg;

  gpio_bank_ctrl u_ctrl (
    .regAddr(regAddr),
    .regWrEn(regWrEn),
    .stb    (stb)
  );

  gpio_bank_dp #(.PINS(PINS)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .stb    (stb),
    .wdata  (regWdata),
    .padIn  (padIn),
    .rdata  (regRdata),
    .padOut (padOut),
    .padOe  (padOe),
    .pullUp (pullUp),
    .pullEn (pullEn),
    .rawStat(rawStat),
    .maskReg(maskReg),
    .irqOut (irqOut)
  );

endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int PINS = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [PINS-1:0]   regWdata,
  input logic [PINS-1:0]   regRdata,
  input logic [PINS-1:0]   padOe,
  input logic [PINS-1:0]   pullUp,
  input logic              irqOut,
  input logic [PINS-1:0]   rawStat,
  input logic [PINS-1:0]   maskReg
);

  logic isMapped;
  assign isMapped = (regAddr == OFS_IN)   || (regAddr == OFS_OUT)  || (regAddr == OFS_OE)   ||
                    (regAddr == OFS_TYPE) || (regAddr == OFS_DUAL) || (regAddr == OFS_POL)  ||
                    (regAddr == OFS_MASK) || (regAddr == OFS_RAW)  || (regAddr == OFS_MSTAT)||
                    (regAddr == OFS_CLR)  || (regAddr == OFS_PSEL) || (regAddr == OFS_PEN);

  // R1: first cycle out of reset is quiet
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (padOe == '0 && !irqOut));

  // R2: a write to the enable register appears on padOe next cycle
  p_oe_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrEn && regAddr == OFS_OE) |=> (padOe == $past(regWdata)));

  // R7: nothing masked in means no interrupt
  p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (maskReg == '0) |-> !irqOut);

  // R8: raw status bits only fall through a clear write
  p_raw_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(regWrEn && regAddr == OFS_CLR) |=> ((rawStat & $past(rawStat)) == $past(rawStat)));

  // R8: clear register reads as zero
  p_clr_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (regAddr == OFS_CLR) |-> (regRdata == '0));

  // R9: pull direction holds without a write to it
  p_pull_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(regWrEn && regAddr == OFS_PSEL) |=> $stable(pullUp));

  // R10: unmapped offsets read zero
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !isMapped |-> (regRdata == '0));

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.PINS(PINS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .regAddr (regAddr),
  .regWrEn (regWrEn),
  .regWdata(regWdata),
  .regRdata(regRdata),
  .padOe   (padOe),
  .pullUp  (pullUp),
  .irqOut  (irqOut),
  .rawStat (rawStat),
  .maskReg (maskReg)
);

// File: tb/sim_gpio_irq_bank.sv
`timescale 1ns/1ps
module sim_gpio_irq_bank;

  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   regAddr = '0;
  logic         regWrEn = 1'b0;
  logic [N-1:0] regWdata = '0;
  logic [N-1:0] regRdata;
  logic [N-1:0] padIn = '0;
  logic [N-1:0] padOut, padOe, pullUp, pullEn;
  logic         irqOut;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic [N-1:0] padCur = '0;

  // reference model state
  logic [N-1:0] mOut, mOe, mType, mDual, mPol, mMask, mRaw, mPs, mPe;
  logic [N-1:0] mS1, mS2, mPrev;

  always #10 clk = ~clk;

  gpio_irq_bank #(.PINS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWdata(regWdata), .regRdata(regRdata), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .pullUp(pullUp), .pullEn(pullEn),
    .irqOut(irqOut)
  );

  task automatic modelClear();
    mOut = '0; mOe = '0; mType = '0; mDual = '0; mPol = '0; mMask = '0;
    mRaw = '0; mPs = '0; mPe = '0; mS1 = '0; mS2 = '0; mPrev = '0;
  endtask

  function automatic logic [N-1:0] modelRead(input logic [7:0] a);
    case (a)
      8'h00: return mS2;
      8'h04: return mOut;
      8'h08: return mOe;
      8'h0c: return mType;
      8'h10: return mDual;
      8'h14: return mPol;
      8'h18: return mMask;
      8'h1c: return mRaw;
      8'h20: return mRaw & mMask;
      8'h34: return mPs;
      8'h38: return mPe;
      default: return '0;
    endcase
  endfunction

  function automatic string tagOf(input logic [7:0] a);
    if (!rst_n) return "R1";
    case (a)
      8'h00: return "R3";
      8'h04, 8'h08: return "R2";
      8'h0c, 8'h10, 8'h14, 8'h1c: return "R4,R5,R6";
      8'h18, 8'h20: return "R7";
      8'h24: return "R8";
      8'h34, 8'h38: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at %0t: actual %h expected %h", tag, what, $time, act, exp);
    end
  endtask

  task automatic modelStep(input logic [7:0] a, input logic we, input logic [N-1:0] wd,
                           input logic [N-1:0] pad);
    logic [N-1:0] ev;
    logic [N-1:0] clr;
    if (!rst_n) begin
      modelClear();
      return;
    end
    for (int i = 0; i < N; i++) begin
      if (mType[i])      ev[i] = mPol[i] ? mS2[i] : !mS2[i];
      else if (mDual[i]) ev[i] = mS2[i] != mPrev[i];
      else if (mPol[i])  ev[i] = mS2[i] && !mPrev[i];
      else               ev[i] = !mS2[i] && mPrev[i];
    end
    clr = (we && a == 8'h24) ? wd : '0;
    for (int i = 0; i < N; i++)
      mRaw[i] = (mRaw[i] && !clr[i]) || ev[i];
    mPrev = mS2; mS2 = mS1; mS1 = pad;
    if (we) begin
      case (a)
        8'h04: mOut = wd;
        8'h08: mOe = wd;
        8'h0c: mType = wd;
        8'h10: mDual = wd;
        8'h14: mPol = wd;
        8'h18: mMask = wd;
        8'h34: mPs = wd;
        8'h38: mPe = wd;
        default: ;
      endcase
    end
  endtask

  // one clock: drive at negedge, compare, advance model, wait next negedge
  task automatic cyc(input logic [7:0] a, input logic we, input logic [N-1:0] wd);
    regAddr = a; regWrEn = we; regWdata = wd; padIn = padCur;
    #1;
    check(tagOf(a), "regRdata", regRdata, modelRead(a));
    check(rst_n ? "R7" : "R1", "irqOut", {{(N-1){1'b0}}, irqOut},
          {{(N-1){1'b0}}, |(mRaw & mMask)});
    check(rst_n ? "R2" : "R1", "padOut", padOut, mOut);
    check(rst_n ? "R2" : "R1", "padOe", padOe, mOe);
    check(rst_n ? "R9" : "R1", "pullUp", pullUp, mPs);
    check(rst_n ? "R9" : "R1", "pullEn", pullEn, mPe);
    modelStep(a, we, wd, padCur);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [N-1:0] d);
    cyc(a, 1'b1, d);
  endtask

  task automatic rd(input logic [7:0] a);
    cyc(a, 1'b0, '0);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) rd(8'h1c);
  endtask

  task automatic readAll();
    logic [7:0] lst[16] = '{8'h00, 8'h04, 8'h08, 8'h0c, 8'h10, 8'h14, 8'h18, 8'h1c,
                            8'h20, 8'h24, 8'h34, 8'h38, 8'h28, 8'h30, 8'h3c, 8'h02};
    for (int k = 0; k < 16; k++) rd(lst[k]);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    modelClear();
    @(negedge clk);
    // R1: reset state, even with writes attempted
    rd(8'h08);
    wr(8'h04, 32'hFFFF_FFFF);
    readAll();
    rst_n = 1'b1;
    readAll();

    // R2, R9: plain registers
    wr(8'h08, 32'hF0F0_1234);
    wr(8'h04, 32'hA5A5_5A5A);
    wr(8'h34, 32'h0F0F_F0F0);
    wr(8'h38, 32'h1234_8765);
    readAll();

    // R3: synchronized input, R5: default falling-edge detection
    padCur = 32'h1234_5678;
    for (int k = 0; k < 4; k++) rd(8'h00);
    padCur = 32'hFFFF_0000;
    for (int k = 0; k < 4; k++) rd(8'h00);
    rd(8'h1c);
    wr(8'h24, 32'h0000_00FF);
    rd(8'h1c);
    wr(8'h24, 32'hFFFF_FFFF);
    padCur = '0;
    idle(4);
    wr(8'h24, 32'hFFFF_FFFF);
    rd(8'h1c);

    // R4, R5, R6: pin0 rising, pin1 falling, pin2 both edges, pin3 high, pin4 low
    wr(8'h0c, 32'h0000_0018);
    wr(8'h14, 32'h0000_000D);
    wr(8'h10, 32'h0000_0004);
    wr(8'h18, 32'h0000_001F);
    wr(8'h24, 32'hFFFF_FFFF);
    idle(3);
    rd(8'h20);
    padCur = 32'h0000_000F;
    idle(4);
    rd(8'h20);
    wr(8'h24, 32'h0000_00FF);
    idle(2);
    padCur = 32'h0000_0010;
    idle(4);
    wr(8'h24, 32'h0000_001F);
    idle(3);
    rd(8'h20);

    // R4: level re-sets after a clear
    padCur = 32'h0000_0018;
    idle(3);
    wr(8'h24, 32'h0000_0008);
    rd(8'h1c);
    rd(8'h20);

    // R8: clear coinciding with a detected edge, swept delay
    for (int d = 0; d < 4; d++) begin
      padCur = 32'h0000_0010;
      idle(4);
      wr(8'h24, 32'hFFFF_FFFF);
      padCur = 32'h0000_0011;
      idle(d);
      wr(8'h24, 32'h0000_0001);
      rd(8'h1c);
      wr(8'h24, 32'h0000_0000);
      rd(8'h24);
    end

    // R7: masking drops the interrupt, raw status kept
    padCur = 32'h0000_0008;
    idle(3);
    wr(8'h18, 32'h0000_0000);
    rd(8'h20);
    rd(8'h1c);
    wr(8'h18, 32'h0000_0008);
    rd(8'h20);

    // R10: unmapped and read-only offsets ignore writes
    wr(8'h28, 32'hFFFF_FFFF);
    wr(8'h2c, 32'hFFFF_FFFF);
    wr(8'h30, 32'hFFFF_FFFF);
    wr(8'h3c, 32'hFFFF_FFFF);
    wr(8'h06, 32'hFFFF_FFFF);
    wr(8'h1c, 32'h0000_0000);
    wr(8'h20, 32'h0000_0000);
    wr(8'h00, 32'hFFFF_FFFF);
    readAll();

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule